// File: doc/BRIEF.md
# Commutation-Synchronized Output Control Preload

This block keeps the per-channel output control set of a motor-drive timer. Each channel has an output enable, a complementary output enable and an output-compare mode field. The active copy of these bits drives the channel outputs. Software writes new values through a write port. Those values either take effect at once or wait in a shadow copy until a commutation event. Deferring them lets every channel switch its drive pattern on the same clock edge at each commutation step.

A commutation event comes from a software strobe. When the trigger select bit is set, a rising edge on a trigger input also causes one. Each event produces a one-cycle pulse and sets a sticky flag that software clears. The block also routes capture/compare DMA requests. Depending on a select bit, each channel's request follows that channel's capture/compare event, or all requests follow the timer update event.

A configuration write loads the preload enable, the trigger select and the DMA select. All state is reset synchronously with an active-high reset. Outputs are registered.

Top module: `com_preload_ctl`

## Requirements
- R1: While preload is off, a cycle with `wr_en` high copies `wr_oe`, `wr_oen` and `wr_mode` into the active outputs on the next clock edge. Channel k's mode field is `wr_mode[k*MODE_W +: MODE_W]`, and it appears at the same position in `act_mode`.
- R2: While preload is on, writes go only to the shadow copy. The active outputs stay unchanged in every cycle with no commutation event, and take the shadow value on the edge that ends a cycle with a commutation event.
- R3: With the trigger select at 0, only `sw_com` causes a commutation event. A trigger edge has no effect on `com_pulse`, `com_flag` or the active outputs.
- R4: With the trigger select at 1, either `sw_com` or a rising edge of `trig_in` causes a commutation event. The rising edge is `trig_in` high in a cycle after a cycle in which it was low, so a trigger held high causes no further events.
- R5: When a write and a commutation event fall in the same cycle while preload is on, the newly written value goes to the active outputs.
- R6: With the DMA select at 0, `dma_req[k]` is `cc_evt[k]` delayed by one cycle. With the DMA select at 1, every bit of `dma_req` is `upd_evt` delayed by one cycle.
- R7: Each commutation event drives `com_pulse` high for the following cycle only, and sets `com_flag`. `com_flag` stays set until a cycle with `flag_clr` high and no commutation event. A commutation event wins over a clear in the same cycle.
- R8: Reset clears the active outputs, the shadow copy, `com_flag`, `com_pulse`, `dma_req` and all three configuration bits. After reset, preload is therefore off.
- R9: A configuration write (`cfg_wr`) takes effect in the cycle after it. The cycle that carries the write still runs under the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the three configuration bits |
| cfg_preload | input | 1 | Preload enable value |
| cfg_trig_sel | input | 1 | 1: trigger rising edge also commutes |
| cfg_dma_upd | input | 1 | 1: DMA requests on update event |
| wr_en | input | 1 | Write strobe for the channel control bits |
| wr_oe | input | NUM_CH | Output enable per channel |
| wr_oen | input | NUM_CH | Complementary output enable per channel |
| wr_mode | input | NUM_CH*MODE_W | Compare mode fields, channel k at k*MODE_W |
| sw_com | input | 1 | Software commutation strobe, one cycle |
| trig_in | input | 1 | Trigger input |
| flag_clr | input | 1 | Clear the sticky commutation flag |
| cc_evt | input | NUM_CH | Capture/compare event per channel |
| upd_evt | input | 1 | Timer update event |
| act_oe | output | NUM_CH | Active output enables |
| act_oen | output | NUM_CH | Active complementary enables |
| act_mode | output | NUM_CH*MODE_W | Active compare mode fields |
| com_pulse | output | 1 | One-cycle commutation event pulse |
| com_flag | output | 1 | Sticky commutation flag |
| dma_req | output | NUM_CH | Capture/compare DMA requests |

## Verification
Two things can fall in the same cycle: a write to the control bits and a commutation event. The flag clear can also coincide with a commutation event. The bench provokes both. It raises `wr_en` together with `sw_com` while preload is on and the trigger is held high. It then raises `flag_clr` together with `sw_com`. The bench judges the first case correct when the freshly written value appears on the active outputs. It judges the second correct when `com_flag` stays set and `com_pulse` fires. A configuration write is also placed in the same cycle as an update event, to confirm that the old DMA routing still governs that cycle.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic {
    DMA_ON_CC  = 1'b0,
    DMA_ON_UPD = 1'b1
  } dma_src_e;

  // synchronous rising-edge test against the previous-cycle sample
  function automatic logic rose_now(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/cps_cfg_regs.sv
module cps_cfg_regs
  import cps_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_wr,
  input  logic     cfg_preload,
  input  logic     cfg_trig_sel,
  input  logic     cfg_dma_upd,
  output logic     preload_q,
  output logic     trig_sel_q,
  output dma_src_e dma_src_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q  <= 1'b0;
      trig_sel_q <= 1'b0;
      dma_src_q  <= DMA_ON_CC;
    end else if (cfg_wr) begin
      preload_q  <= cfg_preload;
      trig_sel_q <= cfg_trig_sel;
      dma_src_q  <= cfg_dma_upd ? DMA_ON_UPD : DMA_ON_CC;
    end
  end

endmodule

// File: rtl/cps_com_detect.sv
module cps_com_detect
  import cps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_com,
  input  logic trig_in,
  input  logic trig_sel_q,
  input  logic flag_clr,
  output logic com_now,
  output logic com_pulse,
  output logic com_flag
);

  logic trig_q;

  always_comb begin
    com_now = sw_com | (trig_sel_q & rose_now(trig_in, trig_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= 1'b0;
      com_pulse <= 1'b0;
      com_flag  <= 1'b0;
    end else begin
      trig_q    <= trig_in;
      com_pulse <= com_now;
      if (com_now)       com_flag <= 1'b1;
      else if (flag_clr) com_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/cps_chan_bank.sv
module cps_chan_bank #(
  parameter int NUM_CH = 2,
  parameter int MODE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     preload_q,
  input  logic                     com_now,
  input  logic                     wr_en,
  input  logic [NUM_CH-1:0]        wr_oe,
  input  logic [NUM_CH-1:0]        wr_oen,
  input  logic [NUM_CH*MODE_W-1:0] wr_mode,
  output logic [NUM_CH-1:0]        act_oe,
  output logic [NUM_CH-1:0]        act_oen,
  output logic [NUM_CH*MODE_W-1:0] act_mode
);

  localparam int SLOT_W = MODE_W + 2;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] shd_q;
    logic [SLOT_W-1:0] act_q;

    assign wr_slot = {wr_oe[k], wr_oen[k], wr_mode[k*MODE_W +: MODE_W]};

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en) shd_q <= wr_slot;
        if (!preload_q) begin
          if (wr_en) act_q <= wr_slot;
        end else if (com_now) begin
          act_q <= wr_en ? wr_slot : shd_q;
        end
      end
    end

    assign act_oe[k]                     = act_q[SLOT_W-1];
    assign act_oen[k]                    = act_q[SLOT_W-2];
    assign act_mode[k*MODE_W +: MODE_W]  = act_q[MODE_W-1:0];
  end

endmodule

// File: rtl/cps_dma_route.sv
module cps_dma_route
  import cps_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dma_src_e          dma_src_q,
  input  logic [NUM_CH-1:0] cc_evt,
  input  logic              upd_evt,
  output logic [NUM_CH-1:0] dma_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req <= '0;
    end else begin
      unique case (dma_src_q)
        DMA_ON_UPD: dma_req <= {NUM_CH{upd_evt}};
        default:    dma_req <= cc_evt;
      endcase
    end
  end

endmodule

// File: rtl/com_preload_ctl.sv
module com_preload_ctl
  import cps_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int MODE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic                     cfg_preload,
  input  logic                     cfg_trig_sel,
  input  logic                     cfg_dma_upd,
  input  logic                     wr_en,
  input  logic [NUM_CH-1:0]        wr_oe,
  input  logic [NUM_CH-1:0]        wr_oen,
  input  logic [NUM_CH*MODE_W-1:0] wr_mode,
  input  logic                     sw_com,
  input  logic                     trig_in,
  input  logic                     flag_clr,
  input  logic [NUM_CH-1:0]        cc_evt,
  input  logic                     upd_evt,
  output logic [NUM_CH-1:0]        act_oe,
  output logic [NUM_CH-1:0]        act_oen,
  output logic [NUM_CH*MODE_W-1:0] act_mode,
  output logic                     com_pulse,
  output logic                     com_flag,
  output logic [NUM_CH-1:0]        dma_req
);

  logic     preload_q;
  logic     trig_sel_q;
  dma_src_e dma_src_q;
  logic     com_now;

  cps_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .cfg_preload(cfg_preload), .cfg_trig_sel(cfg_trig_sel), .cfg_dma_upd(cfg_dma_upd),
    .preload_q(preload_q), .trig_sel_q(trig_sel_q), .dma_src_q(dma_src_q)
  );

  cps_com_detect u_com (
    .clk(clk), .rst(rst), .sw_com(sw_com), .trig_in(trig_in),
    .trig_sel_q(trig_sel_q), .flag_clr(flag_clr),
    .com_now(com_now), .com_pulse(com_pulse), .com_flag(com_flag)
  );

  cps_chan_bank #(.NUM_CH(NUM_CH), .MODE_W(MODE_W)) u_bank (
    .clk(clk), .rst(rst), .preload_q(preload_q), .com_now(com_now),
    .wr_en(wr_en), .wr_oe(wr_oe), .wr_oen(wr_oen), .wr_mode(wr_mode),
    .act_oe(act_oe), .act_oen(act_oen), .act_mode(act_mode)
  );

  cps_dma_route #(.NUM_CH(NUM_CH)) u_dma (
    .clk(clk), .rst(rst), .dma_src_q(dma_src_q),
    .cc_evt(cc_evt), .upd_evt(upd_evt), .dma_req(dma_req)
  );

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int NUM_CH = 2,
  parameter int MODE_W = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [NUM_CH-1:0]        wr_oe,
  input logic [NUM_CH*MODE_W-1:0] wr_mode,
  input logic                     sw_com,
  input logic                     flag_clr,
  input logic [NUM_CH-1:0]        cc_evt,
  input logic                     preload_q,
  input logic                     trig_sel_q,
  input logic                     dma_src_q,
  input logic                     com_now,
  input logic [NUM_CH-1:0]        act_oe,
  input logic [NUM_CH-1:0]        act_oen,
  input logic [NUM_CH*MODE_W-1:0] act_mode,
  input logic                     com_pulse,
  input logic                     com_flag,
  input logic [NUM_CH-1:0]        dma_req
);

  assert_immediate_R1: assert property (@(posedge clk) disable iff (rst)
    (!preload_q && wr_en) |=> (act_oe == $past(wr_oe) && act_mode == $past(wr_mode)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (preload_q && !com_now) |=> ($stable(act_oe) && $stable(act_oen) && $stable(act_mode)));

  assert_sw_only_R3: assert property (@(posedge clk) disable iff (rst)
    (!trig_sel_q && !sw_com) |=> !com_pulse);

  assert_new_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (preload_q && com_now && wr_en) |=> (act_mode == $past(wr_mode)));

  assert_dma_cc_R6: assert property (@(posedge clk) disable iff (rst)
    (dma_src_q == 1'b0) |=> (dma_req == $past(cc_evt)));

  assert_pulse_sets_R7: assert property (@(posedge clk) disable iff (rst)
    com_pulse |-> com_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (com_flag && !flag_clr) |=> com_flag);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (act_oe == '0 && act_oen == '0 && !com_flag && !com_pulse));

endmodule

bind com_preload_ctl cps_checker #(.NUM_CH(NUM_CH), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_oe(wr_oe), .wr_mode(wr_mode),
  .sw_com(sw_com), .flag_clr(flag_clr), .cc_evt(cc_evt),
  .preload_q(preload_q), .trig_sel_q(trig_sel_q), .dma_src_q(dma_src_q),
  .com_now(com_now), .act_oe(act_oe), .act_oen(act_oen), .act_mode(act_mode),
  .com_pulse(com_pulse), .com_flag(com_flag), .dma_req(dma_req)
);

// File: tb/test_com_preload_ctl.sv
module test_com_preload_ctl;

  localparam int NUM_CH = 2;
  localparam int MODE_W = 3;
  localparam int MW     = NUM_CH * MODE_W;

  typedef struct packed {
    logic          cfg_wr, pre, tsel, dsel;
    logic          wr;
    logic [1:0]    oe, oen;
    logic [MW-1:0] mode;
    logic          sw, trig, clr;
    logic [1:0]    cc;
    logic          upd;
    logic [1:0]    e_oe, e_oen;
    logic [MW-1:0] e_mode;
    logic          e_flag, e_pulse;
    logic [1:0]    e_dma;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // 0 R1: immediate write with preload off
    '{0,0,0,0, 1,2'b11,2'b01,6'o53, 0,0,0,2'b00,0, 2'b11,2'b01,6'o53,0,0,2'b00},
    // 1 R9/R6: enable preload, cc routed
    '{1,1,0,0, 0,2'b00,2'b00,6'o00, 0,0,0,2'b10,0, 2'b11,2'b01,6'o53,0,0,2'b10},
    // 2 R2: write into shadow only
    '{0,0,0,0, 1,2'b00,2'b10,6'o12, 0,0,0,2'b00,0, 2'b11,2'b01,6'o53,0,0,2'b00},
    // 3 R3: trigger edge ignored with select 0
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 0,1,0,2'b00,0, 2'b11,2'b01,6'o53,0,0,2'b00},
    // 4 R2/R7: software commutation transfers shadow
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 1,0,0,2'b00,0, 2'b00,2'b10,6'o12,1,1,2'b00},
    // 5 R7: clear flag
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 0,0,1,2'b00,0, 2'b00,2'b10,6'o12,0,0,2'b00},
    // 6 R9/R6: cfg write with update event, old routing still active
    '{1,1,1,1, 0,2'b00,2'b00,6'o00, 0,0,0,2'b01,1, 2'b00,2'b10,6'o12,0,0,2'b01},
    // 7 R6: update routing to all channels
    '{0,0,0,0, 1,2'b01,2'b11,6'o77, 0,0,0,2'b00,1, 2'b00,2'b10,6'o12,0,0,2'b11},
    // 8 R4: trigger rising edge commutes
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 0,1,0,2'b00,0, 2'b01,2'b11,6'o77,1,1,2'b00},
    // 9 R4: held trigger does not retrigger
    '{0,0,0,0, 1,2'b10,2'b00,6'o21, 0,1,0,2'b00,0, 2'b01,2'b11,6'o77,1,0,2'b00},
    // 10 R5: write and commutation same cycle
    '{0,0,0,0, 1,2'b11,2'b11,6'o44, 1,1,0,2'b00,0, 2'b11,2'b11,6'o44,1,1,2'b00},
    // 11 R7: commutation beats clear
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 1,1,1,2'b00,0, 2'b11,2'b11,6'o44,1,1,2'b00},
    // 12 R7: clear alone
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 0,1,1,2'b00,0, 2'b11,2'b11,6'o44,0,0,2'b00},
    // 13 R9: preload off written, still preloaded this cycle
    '{1,0,0,0, 1,2'b00,2'b00,6'o00, 0,0,0,2'b00,0, 2'b11,2'b11,6'o44,0,0,2'b00},
    // 14 R1: immediate again
    '{0,0,0,0, 1,2'b10,2'b01,6'o35, 0,0,0,2'b00,0, 2'b10,2'b01,6'o35,0,0,2'b00},
    // 15 R7: commutation with preload off still flags
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 1,0,0,2'b00,0, 2'b10,2'b01,6'o35,1,1,2'b00},
    // 16 R3: trigger rise with select 0 gives no pulse
    '{0,0,0,0, 0,2'b00,2'b00,6'o00, 0,1,0,2'b00,0, 2'b10,2'b01,6'o35,1,0,2'b00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_preload = 0, cfg_trig_sel = 0, cfg_dma_upd = 0;
  logic wr_en = 0;
  logic [NUM_CH-1:0] wr_oe = '0, wr_oen = '0, cc_evt = '0;
  logic [MW-1:0] wr_mode = '0;
  logic sw_com = 0, trig_in = 0, flag_clr = 0, upd_evt = 0;
  logic [NUM_CH-1:0] act_oe, act_oen, dma_req;
  logic [MW-1:0] act_mode;
  logic com_pulse, com_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  com_preload_ctl #(.NUM_CH(NUM_CH), .MODE_W(MODE_W)) i_com_preload_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_preload(cfg_preload),
    .cfg_trig_sel(cfg_trig_sel), .cfg_dma_upd(cfg_dma_upd),
    .wr_en(wr_en), .wr_oe(wr_oe), .wr_oen(wr_oen), .wr_mode(wr_mode),
    .sw_com(sw_com), .trig_in(trig_in), .flag_clr(flag_clr),
    .cc_evt(cc_evt), .upd_evt(upd_evt),
    .act_oe(act_oe), .act_oen(act_oen), .act_mode(act_mode),
    .com_pulse(com_pulse), .com_flag(com_flag), .dma_req(dma_req)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_preload = 0; cfg_trig_sel = 0; cfg_dma_upd = 0;
    wr_en = 0; wr_oe = '0; wr_oen = '0; wr_mode = '0;
    sw_com = 0; trig_in = 0; flag_clr = 0; cc_evt = '0; upd_evt = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check("R8 reset act_oe",  16'(act_oe),   16'(0));
    check("R8 reset act_mode", 16'(act_mode), 16'(0));
    check("R8 reset flags",   {14'b0, com_flag, com_pulse}, 16'(0));
    check("R8 reset dma",     16'(dma_req),  16'(0));

    for (int i = 0; i < NV; i++) begin
      cfg_wr = VECS[i].cfg_wr; cfg_preload = VECS[i].pre;
      cfg_trig_sel = VECS[i].tsel; cfg_dma_upd = VECS[i].dsel;
      wr_en = VECS[i].wr; wr_oe = VECS[i].oe; wr_oen = VECS[i].oen; wr_mode = VECS[i].mode;
      sw_com = VECS[i].sw; trig_in = VECS[i].trig; flag_clr = VECS[i].clr;
      cc_evt = VECS[i].cc; upd_evt = VECS[i].upd;
      @(negedge clk);
      check($sformatf("R1/R2/R5 active set vec %0d", i),
            16'({act_oe, act_oen, act_mode}),
            16'({VECS[i].e_oe, VECS[i].e_oen, VECS[i].e_mode}));
      check($sformatf("R7 com_flag vec %0d", i), 16'(com_flag), 16'(VECS[i].e_flag));
      check($sformatf("R3/R4 com_pulse vec %0d", i), 16'(com_pulse), 16'(VECS[i].e_pulse));
      check($sformatf("R6 dma_req vec %0d", i), 16'(dma_req), 16'(VECS[i].e_dma));
    end

    // R8: mid-run reset clears preload and flag; next write is immediate
    idle_inputs();
    cfg_wr = 1; cfg_preload = 1;
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid-run reset act", 16'({act_oe, act_oen, act_mode}), 16'(0));
    check("R8 mid-run reset flag", 16'(com_flag), 16'(0));
    wr_en = 1; wr_oe = 2'b01; wr_oen = 2'b10; wr_mode = 6'o62;
    @(negedge clk);
    idle_inputs();
    check("R8 preload off after reset", 16'({act_oe, act_oen, act_mode}),
          16'({2'b01, 2'b10, 6'o62}));

    // R4: trigger edge with select 1 after a low cycle, preload on
    cfg_wr = 1; cfg_preload = 1; cfg_trig_sel = 1;
    @(negedge clk);
    idle_inputs();
    wr_en = 1; wr_oe = 2'b10; wr_oen = 2'b00; wr_mode = 6'o07;
    @(negedge clk);
    idle_inputs();
    check("R2 shadow held", 16'({act_oe, act_oen, act_mode}), 16'({2'b01, 2'b10, 6'o62}));
    trig_in = 1;
    @(negedge clk);
    check("R4 trigger edge transfer", 16'({act_oe, act_oen, act_mode}),
          16'({2'b10, 2'b00, 6'o07}));
    check("R4 trigger edge pulse", 16'(com_pulse), 16'(1));
    @(negedge clk);
    check("R7 pulse lasts one cycle", 16'(com_pulse), 16'(0));
    idle_inputs();
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule